// File: doc/BRIEF.md
# Mask-Driven Stream Compaction Unit

This block takes a vector of N data words and one select bit for each word. It packs the selected words into the lowest output slots and keeps their original relative order. It also reports how many words it kept. A one-cycle start strobe latches the whole vector and its select bits.

The destination of every selected word is the exclusive prefix sum of the select bits. This sum is the number of selected words below that word's own position. The sum is built by a logarithmic shift-and-add network. The network executes one stage per clock: pass k adds to each entry the entry 2^k positions lower, with zeros filled in below index 0. After log2(N) passes, a scatter stage routes each selected word to its slot. The same cycle registers the packed vector, the kept count and a one-cycle done pulse.

Worked example, with data 0..9 and select bits 1,0,1,0,1,0,0,1,1,0:
- The exclusive sum of the select bits is 0,1,1,2,2,3,3,3,4,5.
- The packed result is 0,2,4,7,8.
- The count is 5.

Top module: `stream_pack`

## Requirements
- R1: Word i occupies bits [i*W +: W] of both `in_data` and `out_data`, and select bit i is `in_sel[i]`. A selected word i is written to output slot j. Here j is the number of selected words at positions below i, so the packed words keep their input order.
- R2: Every output slot whose index is at or above `out_count` reads zero.
- R3: `out_count` equals the number of ones in the select vector latched at the accepted start.
- R4: `start` is accepted when it is high at a rising edge while the unit is idle. `done` goes high right after the log2(N)+1-th rising edge that follows the accepting edge. It stays high for exactly one cycle.
- R5: A `start` that is high while a run is in progress has no effect. That run finishes at its own time, with its own results.
- R6: An all-zero select vector gives a count of 0 and an all-zero output vector.
- R7: An all-ones select vector gives a count of N and an output vector equal to the input vector.
- R8: `out_data` and `out_count` change only in the cycle in which `done` is high. They hold their values until the next done pulse.
- R9: A synchronous active-high reset clears `done`, `out_count` and `out_data` to zero and returns the unit to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe; latches `in_data` and `in_sel` when idle |
| in_data | input | N*W | Input words, word i at bits [i*W +: W] |
| in_sel | input | N | Select bit per word |
| out_data | output | N*W | Packed words, slot j at bits [j*W +: W] |
| out_count | output | $clog2(N)+1 | Number of kept words |
| done | output | 1 | One-cycle pulse when results are valid |

## Verification
A wrong prefix-sum entry in any scan pass appears at the ports in the very next done cycle. Its word lands in the wrong slot, collides with a neighbour, or leaves a nonzero word above the count. A miscounted pass or a badly handled intruding start moves or repeats the done pulse, so the run comes out early, late or twice. Random select patterns are compared slot by slot against a bench model. Together with the all-zero, all-one, single-end-bit and worked-example vectors, this reaches every pass offset and both boundary slots.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SCAN = 2'd1,
    PH_EMIT = 2'd2
  } sp_phase_t;

  function automatic int unsigned sp_idx_w(input int unsigned passes);
    return (passes > 1) ? $clog2(passes) : 1;
  endfunction
endpackage

// File: rtl/sp_ctrl.sv
module sp_ctrl
  import sp_pkg::*;
#(
  parameter int unsigned PASSES = 4,
  parameter int unsigned IW     = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          load,
  output logic          step,
  output logic          emit,
  output logic          busy,
  output logic [IW-1:0] pass_idx
);
  sp_phase_t phase_q;
  logic [IW-1:0] cnt_q;

  assign busy     = (phase_q != PH_IDLE);
  assign load     = (phase_q == PH_IDLE) && start;
  assign step     = (phase_q == PH_SCAN);
  assign emit     = (phase_q == PH_EMIT);
  assign pass_idx = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_SCAN;
          cnt_q   <= '0;
        end
        PH_SCAN: begin
          if (cnt_q == IW'(PASSES - 1)) phase_q <= PH_EMIT;
          else cnt_q <= cnt_q + 1'b1;
        end
        PH_EMIT: phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sp_scan_pass.sv
module sp_scan_pass #(
  parameter int unsigned N   = 16,
  parameter int unsigned CW  = 5,
  parameter int unsigned OFS = 1
) (
  input  logic [N*CW-1:0] din,
  output logic [N*CW-1:0] dout
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    if (i >= OFS) begin : g_add
      assign dout[i*CW +: CW] = din[i*CW +: CW] + din[(i-OFS)*CW +: CW];
    end else begin : g_keep
      assign dout[i*CW +: CW] = din[i*CW +: CW];
    end
  end
endmodule

// File: rtl/sp_scatter.sv
module sp_scatter #(
  parameter int unsigned N  = 16,
  parameter int unsigned W  = 16,
  parameter int unsigned CW = 5
) (
  input  logic [N*W-1:0]  data,
  input  logic [N-1:0]    sel,
  input  logic [N*CW-1:0] dest,
  output logic [N*W-1:0]  packed_o
);
  for (genvar j = 0; j < N; j++) begin : g_slot
    logic [W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int i = 0; i < N; i++) begin
        if (sel[i] && (dest[i*CW +: CW] == CW'(j))) acc = acc | data[i*W +: W];
      end
    end
    assign packed_o[j*W +: W] = acc;
  end
endmodule

// File: rtl/stream_pack.sv
module stream_pack
  import sp_pkg::*;
#(
  parameter int unsigned N = 16,
  parameter int unsigned W = 16,
  localparam int unsigned CW = $clog2(N) + 1,
  localparam int unsigned PASSES = $clog2(N),
  localparam int unsigned IW = sp_idx_w(PASSES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [N*W-1:0] in_data,
  input  logic [N-1:0]  in_sel,
  output logic [N*W-1:0] out_data,
  output logic [CW-1:0] out_count,
  output logic          done
);
  logic          load, step, emit, busy;
  logic [IW-1:0] pass_idx;
  logic [N*W-1:0]  data_q;
  logic [N-1:0]    sel_q;
  logic [N*CW-1:0] scan_q;
  logic [N*CW-1:0] pass_out [PASSES];
  logic [N*CW-1:0] seed;
  logic [N*W-1:0]  packed_w;

  sp_ctrl #(.PASSES(PASSES), .IW(IW)) i_ctrl (
    .clk(clk), .rst(rst), .start(start), .load(load), .step(step),
    .emit(emit), .busy(busy), .pass_idx(pass_idx)
  );

  for (genvar k = 0; k < PASSES; k++) begin : g_pass
    sp_scan_pass #(.N(N), .CW(CW), .OFS(1 << k)) i_pass (
      .din(scan_q), .dout(pass_out[k])
    );
  end

  for (genvar i = 0; i < N; i++) begin : g_seed
    if (i == 0) begin : g_zero
      assign seed[CW-1:0] = '0;
    end else begin : g_prev
      assign seed[i*CW +: CW] = CW'(in_sel[i-1]);
    end
  end

  sp_scatter #(.N(N), .W(W), .CW(CW)) i_scatter (
    .data(data_q), .sel(sel_q), .dest(scan_q), .packed_o(packed_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q    <= '0;
      sel_q     <= '0;
      scan_q    <= '0;
      out_data  <= '0;
      out_count <= '0;
      done      <= 1'b0;
    end else begin
      done <= emit;
      if (load) begin
        data_q <= in_data;
        sel_q  <= in_sel;
        scan_q <= seed;
      end else if (step) begin
        scan_q <= pass_out[pass_idx];
      end
      if (emit) begin
        out_data  <= packed_w;
        out_count <= scan_q[(N-1)*CW +: CW] + CW'(sel_q[N-1]);
      end
    end
  end
endmodule

// File: rtl/stream_pack_chk.sv
module stream_pack_chk #(
  parameter int unsigned N = 16,
  parameter int unsigned W = 16,
  parameter int unsigned CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic [N-1:0]  in_sel,
  input logic [N*W-1:0] out_data,
  input logic [CW-1:0] out_count,
  input logic          done
);
  localparam int unsigned DUE = $clog2(N) + 2;
  logic          active;
  logic [CW+1:0] tcnt;
  logic [N-1:0]  cap_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      tcnt    <= '0;
      cap_sel <= '0;
    end else if (start && !busy) begin
      active  <= 1'b1;
      tcnt    <= 1;
      cap_sel <= in_sel;
    end else if (done) begin
      active <= 1'b0;
    end else if (active) begin
      tcnt <= tcnt + 1'b1;
    end
  end

  // R4 and R5: done only at the due count of the accepted run
  a_r4_done_on_time: assert property (@(posedge clk) disable iff (rst)
    done |-> (active && tcnt == (CW+2)'(DUE)));
  a_r5_no_restart: assert property (@(posedge clk) disable iff (rst)
    (active && tcnt == (CW+2)'(DUE)) |-> done);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r3_count_match: assert property (@(posedge clk) disable iff (rst)
    done |-> (32'(out_count) == $countones(cap_sel)));
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !done) |-> ($stable(out_data) && $stable(out_count)));
  a_r9_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done && out_count == '0 && out_data == '0));

  for (genvar j = 0; j < N; j++) begin : g_zero
    a_r2_zero_fill: assert property (@(posedge clk) disable iff (rst)
      (32'(out_count) <= j) |-> (out_data[j*W +: W] == '0));
  end
endmodule

bind stream_pack stream_pack_chk #(.N(N), .W(W), .CW(CW)) i_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .in_sel(in_sel),
  .out_data(out_data), .out_count(out_count), .done(done)
);

// File: tb/test_stream_pack.sv
module test_stream_pack;
  localparam int N = 16;
  localparam int W = 16;
  localparam int CW = $clog2(N) + 1;
  localparam int L = $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [N*W-1:0] in_data = '0;
  logic [N-1:0]   in_sel = '0;
  logic [N*W-1:0] out_data;
  logic [CW-1:0]  out_count;
  logic done;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  stream_pack #(.N(N), .W(W)) i_stream_pack (
    .clk(clk), .rst(rst), .start(start), .in_data(in_data), .in_sel(in_sel),
    .out_data(out_data), .out_count(out_count), .done(done)
  );

  function automatic logic [N*W-1:0] exp_pack(input logic [N*W-1:0] d, input logic [N-1:0] m);
    logic [N*W-1:0] r = '0;
    int slot = 0;
    for (int i = 0; i < N; i++) begin
      if (m[i]) begin
        r[slot*W +: W] = d[i*W +: W];
        slot++;
      end
    end
    return r;
  endfunction

  function automatic int exp_count(input logic [N-1:0] m);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(m[i]);
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [N*W-1:0] act,
                       input logic [N*W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one run; intrude drives a second start while busy (R5)
  task automatic do_run(input logic [N*W-1:0] d, input logic [N-1:0] m,
                        input bit intrude, input string tag);
    logic [N*W-1:0] ed = exp_pack(d, m);
    int ec = exp_count(m);
    bit timing_ok = 1'b1;
    @(negedge clk);
    in_data = d; in_sel = m; start = 1'b1;
    for (int k = 1; k <= L + 2; k++) begin
      @(negedge clk);
      if (k == 1) begin
        start = 1'b0; in_data = ~d; in_sel = ~m;
      end
      if (intrude && k == 2) start = 1'b1;
      if (intrude && k == 3) start = 1'b0;
      if (done !== (k == L + 2)) timing_ok = 1'b0;
    end
    check(timing_ok, {tag, " R4 done timing"}, {{(N*W-1){1'b0}}, done}, 1);
    check(out_data === ed, {tag, " R1 packed data"}, out_data, ed);
    check(int'(out_count) == ec, {tag, " R3 count"}, out_count, ec);
    @(negedge clk);
    check(!done && out_data === ed && int'(out_count) == ec,
          {tag, " R8 hold after done"}, out_data, ed);
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N*W-1:0] d;
    logic [N-1:0] m;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!done && out_count == '0 && out_data == '0, "R9 reset state", out_data, '0);

    // worked example: data 0..15, select 1,0,1,0,1,0,0,1,1,0 then zeros
    for (int i = 0; i < N; i++) d[i*W +: W] = W'(i);
    m = '0;
    m[0] = 1; m[2] = 1; m[4] = 1; m[7] = 1; m[8] = 1;
    do_run(d, m, 1'b0, "example R2");

    for (int i = 0; i < N; i++) d[i*W +: W] = W'($urandom);
    do_run(d, '0, 1'b0, "all-zero R6");
    check(out_data == '0 && out_count == '0, "R6 zero output", out_data, '0);
    do_run(d, '1, 1'b0, "all-one R7");
    check(out_data === d && int'(out_count) == N, "R7 output equals input", out_data, d);
    m = '0; m[N-1] = 1'b1;
    do_run(d, m, 1'b0, "last-only R1");
    m = '0; m[0] = 1'b1;
    do_run(d, m, 1'b0, "first-only R2");

    // R5: intruding start during a run
    for (int i = 0; i < N; i++) d[i*W +: W] = W'($urandom);
    do_run(d, N'($urandom), 1'b1, "intrude R5");

    for (int r = 0; r < 40; r++) begin
      for (int i = 0; i < N; i++) d[i*W +: W] = W'($urandom);
      m = N'($urandom);
      if (r % 4 == 0) m = m & N'($urandom);
      do_run(d, m, (r % 5 == 0), "random R1");
    end

    // R9: reset mid-run clears outputs
    @(negedge clk);
    in_data = d; in_sel = '1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < L + 3; k++) begin
      @(negedge clk);
      check(!done && out_count == '0, "R9 reset aborts run", out_data, '0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule